// File: doc/BRIEF.md
# PCM Channel Path Controller

This block sits between one codec channel's converter side and a shared time-division PCM bus. It routes the compressed 8-bit samples in both directions under an 8-bit control word. On the transmit side it chooses what goes onto the bus: the encoder's sample, a forced all-zero byte, or the byte just received from the bus (digital loopback). It drives the bus output enable only during the channel's own time slot, and only when neither the tri-state control bit nor the standby input is asserted.

On the receive side it chooses what goes to the decoder: the byte from the bus, the encoder's own sample (analog loopback), or the idle-channel code. The idle-channel code depends on the companding law chosen in the control word. Both outputs are registered, so every result appears one clock after the inputs that produce it. Compression, expansion and bus timing are outside this block. The enclosing channel logic supplies the slot strobe and the control word.

Top module: `pcm_path_top`

## Requirements
- R1: While `rstN` is low, `txEn`, `txByte` and `rxByte` are all zero.
- R2: `txEn` equals the value of (`slotActive` AND NOT `ctrlReg[7]` AND NOT `standby`) sampled at the previous rising clock edge. Standby forces it low whatever `ctrlReg[7]` holds.
- R3: Whenever `txEn` is low, `txByte` is 0x00.
- R4: If `ctrlReg[6]` was set at the previous edge, `txByte` is 0x00, whatever the encoder sample or the loopback setting.
- R5: If `txEn` is high, `ctrlReg[6]` was clear and `ctrlReg[3]` was set at the previous edge, `txByte` equals `rxBus` of that edge (digital loopback).
- R6: If `txEn` is high and both `ctrlReg[6]` and `ctrlReg[3]` were clear, `txByte` equals `encSample` of the previous edge.
- R7: If `ctrlReg[4]` was set at the previous edge, `rxByte` is the idle code. The code is 0xFF when `ctrlReg[0]` was 0 (mu-law) and 0xD5 when `ctrlReg[0]` was 1 (A-law). This setting overrides analog loopback.
- R8: If `ctrlReg[4]` was clear and `ctrlReg[2]` was set, `rxByte` equals `encSample` of the previous edge (analog loopback).
- R9: If `ctrlReg[4]` and `ctrlReg[2]` were both clear, `rxByte` equals `rxBus` of the previous edge.
- R10: Reserved bits `ctrlReg[5]` and `ctrlReg[1]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlReg | input | 8 | Channel control word (bit 7 tri-state, 6 zero force, 4 idle insert, 3 digital loop, 2 analog loop, 0 law; 5 and 1 reserved) |
| standby | input | 1 | Channel standby; forces the transmit driver off |
| slotActive | input | 1 | High during the channel's assigned bus time slot |
| encSample | input | 8 | Compressed sample from the encoder |
| rxBus | input | 8 | Byte received from the PCM bus |
| txByte | output | 8 | Byte to drive onto the PCM bus |
| txEn | output | 1 | Bus output enable for `txByte` |
| rxByte | output | 8 | Byte delivered to the decoder |

## Verification
Every output is recomputed at every edge from the inputs at that edge. A wrong priority or a wrong select therefore shows at the ports one clock later, on the first cycle whose control word takes the faulty branch. A law bit read from the wrong position shows as 0xFF where 0xD5 belongs, or the reverse, as soon as idle insertion is on. An enable that ignores standby, or a reserved bit that leaks into a select, shows on the next slot that combines the affected settings. Random control words with directed overrides reach each such combination many times.

// File: rtl/pcm_path_pkg.sv
package pcm_path_pkg;

  localparam int CTRL_W       = 8;
  localparam int BIT_HIZ      = 7;
  localparam int BIT_ZERO     = 6;
  localparam int BIT_RSV_HI   = 5;
  localparam int BIT_IDLE     = 4;
  localparam int BIT_DIG_LOOP = 3;
  localparam int BIT_ANA_LOOP = 2;
  localparam int BIT_RSV_LO   = 1;
  localparam int BIT_LAW      = 0;

  typedef struct packed {
    logic driveEn;    // bus driver may be on this cycle
    logic forceZero;  // transmit all-zero byte
    logic digLoop;    // bus receive byte returned to transmit
    logic anaLoop;    // encoder byte returned to receive
    logic rxIdle;     // idle code replaces receive byte
    logic aLaw;       // law select for idle code
  } pathStrobes_t;

endpackage

// File: rtl/pcm_path_ctrl.sv
module pcm_path_ctrl
  import pcm_path_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic              standby,
  input  logic              slotActive,
  output pathStrobes_t      strobes
);

  logic unusedRsv;
  assign unusedRsv = ctrlReg[BIT_RSV_HI] ^ ctrlReg[BIT_RSV_LO];

  logic hiZ;
  assign hiZ = ctrlReg[BIT_HIZ] | standby;

  always_comb begin
    strobes.driveEn   = slotActive & ~hiZ;
    strobes.forceZero = ctrlReg[BIT_ZERO];
    strobes.digLoop   = ctrlReg[BIT_DIG_LOOP];
    strobes.anaLoop   = ctrlReg[BIT_ANA_LOOP];
    strobes.rxIdle    = ctrlReg[BIT_IDLE];
    strobes.aLaw      = ctrlReg[BIT_LAW];
  end

endmodule

// File: rtl/pcm_path_dp.sv
module pcm_path_dp
  import pcm_path_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] IDLE_MU = 8'hFF,
  parameter logic [DATA_W-1:0] IDLE_A  = 8'hD5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobes_t      strobes,
  input  logic [DATA_W-1:0] encSample,
  input  logic [DATA_W-1:0] rxBus,
  output logic [DATA_W-1:0] txByte,
  output logic              txEn,
  output logic [DATA_W-1:0] rxByte
);

  localparam logic [DATA_W-1:0] ZERO_BYTE = '0;

  logic [DATA_W-1:0] txNext;
  logic [DATA_W-1:0] rxNext;
  logic [DATA_W-1:0] idleCode;

  assign idleCode = strobes.aLaw ? IDLE_A : IDLE_MU;

  // transmit priority: driver off, zero force, digital loop, encoder
  always_comb begin
    if (!strobes.driveEn)      txNext = ZERO_BYTE;
    else if (strobes.forceZero) txNext = ZERO_BYTE;
    else if (strobes.digLoop)   txNext = rxBus;
    else                        txNext = encSample;
  end

  // receive priority: idle code, analog loop, bus byte
  always_comb begin
    if (strobes.rxIdle)       rxNext = idleCode;
    else if (strobes.anaLoop) rxNext = encSample;
    else                      rxNext = rxBus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte <= ZERO_BYTE;
      txEn   <= 1'b0;
      rxByte <= ZERO_BYTE;
    end else begin
      txByte <= txNext;
      txEn   <= strobes.driveEn;
      rxByte <= rxNext;
    end
  end

endmodule

// File: rtl/pcm_path_top.sv
module pcm_path_top
  import pcm_path_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] IDLE_MU = 8'hFF,
  parameter logic [DATA_W-1:0] IDLE_A  = 8'hD5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic              standby,
  input  logic              slotActive,
  input  logic [DATA_W-1:0] encSample,
  input  logic [DATA_W-1:0] rxBus,
  output logic [DATA_W-1:0] txByte,
  output logic              txEn,
  output logic [DATA_W-1:0] rxByte
);

  pathStrobes_t strobes;

  pcm_path_ctrl ctrlInst (
    .ctrlReg    (ctrlReg),
    .standby    (standby),
    .slotActive (slotActive),
    .strobes    (strobes)
  );

  pcm_path_dp #(
    .DATA_W  (DATA_W),
    .IDLE_MU (IDLE_MU),
    .IDLE_A  (IDLE_A)
  ) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .encSample (encSample),
    .rxBus     (rxBus),
    .txByte    (txByte),
    .txEn      (txEn),
    .rxByte    (rxByte)
  );

endmodule

// File: rtl/pcm_path_chk.sv
module pcm_path_chk
  import pcm_path_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] IDLE_MU = 8'hFF,
  parameter logic [DATA_W-1:0] IDLE_A  = 8'hD5
) (
  input logic              clk,
  input logic              rstN,
  input logic [CTRL_W-1:0] ctrlReg,
  input logic              standby,
  input logic              slotActive,
  input logic [DATA_W-1:0] encSample,
  input logic [DATA_W-1:0] rxBus,
  input logic [DATA_W-1:0] txByte,
  input logic              txEn,
  input logic [DATA_W-1:0] rxByte
);

  // R1
  always_comb begin
    if (!rstN) begin
      reset_clear_chk: assert (txEn == 1'b0 && txByte == '0 && rxByte == '0);
    end
  end

  // R2
  enable_follows_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> txEn == $past(slotActive && !ctrlReg[BIT_HIZ] && !standby));

  // R3
  off_slot_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |-> txByte == '0);

  // R4
  zero_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrlReg[BIT_ZERO])) |-> txByte == '0);

  // R5
  digital_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && txEn && $past(!ctrlReg[BIT_ZERO] && ctrlReg[BIT_DIG_LOOP]))
      |-> txByte == $past(rxBus));

  // R7
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrlReg[BIT_IDLE]))
      |-> rxByte == ($past(ctrlReg[BIT_LAW]) ? IDLE_A : IDLE_MU));

  // R8
  analog_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!ctrlReg[BIT_IDLE] && ctrlReg[BIT_ANA_LOOP]))
      |-> rxByte == $past(encSample));

endmodule

bind pcm_path_top pcm_path_chk #(
  .DATA_W  (DATA_W),
  .IDLE_MU (IDLE_MU),
  .IDLE_A  (IDLE_A)
) chkInst (.*);

// File: tb/pcm_path_top_test.sv
module pcm_path_top_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] ctrlReg;
  logic       standby;
  logic       slotActive;
  logic [7:0] encSample;
  logic [7:0] rxBus;
  logic [7:0] txByte;
  logic       txEn;
  logic [7:0] rxByte;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_path_top uut (
    .clk(clk), .rstN(rstN), .ctrlReg(ctrlReg), .standby(standby),
    .slotActive(slotActive), .encSample(encSample), .rxBus(rxBus),
    .txByte(txByte), .txEn(txEn), .rxByte(rxByte)
  );

  function automatic logic expEn(logic [7:0] c, logic sb, logic sl);
    return sl && !c[7] && !sb;
  endfunction

  function automatic logic [7:0] expTx(logic [7:0] c, logic sb, logic sl,
                                       logic [7:0] enc, logic [7:0] rx);
    if (!expEn(c, sb, sl)) return 8'h00;
    if (c[6]) return 8'h00;
    if (c[3]) return rx;
    return enc;
  endfunction

  function automatic logic [7:0] expRx(logic [7:0] c, logic [7:0] enc, logic [7:0] rx);
    if (c[4]) return c[0] ? 8'hD5 : 8'hFF;
    if (c[2]) return enc;
    return rx;
  endfunction

  function automatic string txTag(logic [7:0] c, logic sb, logic sl);
    if (!expEn(c, sb, sl)) return "R3";
    if (c[6]) return "R4";
    if (c[3]) return "R5";
    return "R6";
  endfunction

  function automatic string rxTag(logic [7:0] c);
    if (c[4]) return "R7";
    if (c[2]) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive at falling edge, sample just after the next rising edge
  task automatic step(logic [7:0] c, logic sb, logic sl, logic [7:0] enc, logic [7:0] rx);
    @(negedge clk);
    ctrlReg = c; standby = sb; slotActive = sl; encSample = enc; rxBus = rx;
    @(posedge clk);
    #1;
    check("R2", {7'd0, txEn}, {7'd0, expEn(c, sb, sl)});
    check(txTag(c, sb, sl), txByte, expTx(c, sb, sl, enc, rx));
    check(rxTag(c), rxByte, expRx(c, enc, rx));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; ctrlReg = 8'hFF; standby = 1'b0; slotActive = 1'b1;
    encSample = 8'h5A; rxBus = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held at zero in reset despite active inputs
    check("R1", {7'd0, txEn}, 8'h00);
    check("R1", txByte, 8'h00);
    check("R1", rxByte, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // directed corners
    step(8'h00, 1'b0, 1'b1, 8'h3C, 8'hC3);   // R6 R9 plain path
    step(8'h00, 1'b1, 1'b1, 8'h3C, 8'hC3);   // R2 standby alone
    step(8'h80, 1'b0, 1'b1, 8'h3C, 8'hC3);   // R2 tri-state bit
    step(8'h00, 1'b0, 1'b0, 8'h3C, 8'hC3);   // R3 outside slot
    step(8'h48, 1'b0, 1'b1, 8'h77, 8'h11);   // R4 over digital loop
    step(8'h08, 1'b0, 1'b1, 8'h77, 8'h11);   // R5
    step(8'h10, 1'b0, 1'b1, 8'h77, 8'h11);   // R7 mu-law 0xFF
    step(8'h11, 1'b0, 1'b1, 8'h77, 8'h11);   // R7 A-law 0xD5
    step(8'h14, 1'b0, 1'b1, 8'h77, 8'h11);   // R7 over analog loop
    step(8'h04, 1'b0, 1'b1, 8'h77, 8'h11);   // R8
    step(8'h0C, 1'b0, 1'b1, 8'h9E, 8'h2B);   // R5 and R8 together

    // R10: reserved bits set must match the clean-control outputs
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c;
      logic [7:0] ta, ra, tb2, rb2;
      logic       ea, eb;
      c = 8'($urandom) & 8'hDD;
      step(c, 1'b0, 1'b1, 8'h6D, 8'hB2);
      ta = txByte; ra = rxByte; ea = txEn;
      step(c | 8'h22, 1'b0, 1'b1, 8'h6D, 8'hB2);
      tb2 = txByte; rb2 = rxByte; eb = txEn;
      check("R10", tb2, ta);
      check("R10", rb2, ra);
      check("R10", {7'd0, eb}, {7'd0, ea});
    end

    // constrained random: reserved bits kept clear, slot high most cycles
    for (int i = 0; i < 400; i++) begin
      step(8'($urandom) & 8'hDD, ($urandom % 8) == 0, ($urandom % 4) != 0,
           8'($urandom), 8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule